// File: doc/BRIEF.md
# Quantizing 8x8 Cosine Transform Engine

This block turns a square tile of 64 unsigned 8-bit picture samples into 64 quantized frequency coefficients. The whole tile is presented at once on a wide parallel bus. A one-cycle `start` pulse makes the block capture the tile. One 8-point fast transform lane is then used sixteen times: eight passes over the rows of a working store, then eight passes over its columns. A final step divides every coefficient by 256 and rounds it. The divide is the 1/4 output scale of the two-dimensional transform folded together with a fixed quantization step of 64.

Values inside the block are kept as a sign bit beside an unsigned fixed-point magnitude with 12 fraction bits. The 8-point lane follows a recursive split. Mirrored input pairs are summed and differenced. Each difference is scaled by a reciprocal-cosine constant, and the same split is repeated on the half-length sequences. The outputs are gathered in interleaved even/odd order, and neighbouring odd partial results are summed. The result is reported as 64 magnitudes of 8 bits, a 64-bit negative-flag vector and a `done` flag. All of them stay valid until the next accepted start.

Top module: `dct8x8_q`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `done` is 0 and `coef_mag` and `coef_neg` are all zero.
- R2: A `start` pulse is accepted when no computation is running. `done` falls on the accepting clock edge and rises exactly 17 rising edges later.
- R3: While a computation is running, `start` pulses and changes on `pix_blk` are ignored. `done` still rises 17 edges after the original acceptance, and the result belongs to the tile captured at that edge.
- R4: Pixel (r,c), with r the row and c the column, occupies bits [8(8r+c)+7 : 8(8r+c)] of `pix_blk`. Coefficient (u,v), with u the vertical and v the horizontal frequency, occupies the same bit slot of `coef_mag` and bit 8u+v of `coef_neg`. A tile that varies only along columns produces energy at (0,1) and none at (1,0), and the reverse holds for a tile that varies only along rows.
- R5: Each signed coefficient (negative when its `coef_neg` bit is 1) is within 1 of round(Y(u,v)/256). Here Y(u,v) = sum over r,c of p(r,c)·cos((2c+1)vπ/16)·cos((2r+1)uπ/16), and halves round away from zero.
- R6: An all-zero tile gives all-zero magnitudes and negative flags.
- R7: A tile with every pixel 255 gives exactly 64 at (0,0) and 0 at every other position.
- R8: A negative coefficient is reported as a non-zero magnitude with its `coef_neg` bit set. A zero magnitude always has its `coef_neg` bit clear.
- R9: Once `done` is high, it stays high and `coef_mag` and `coef_neg` hold their values until the next accepted `start`, whatever `pix_blk` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to capture the tile and transform it |
| pix_blk | input | 512 | 64 unsigned 8-bit pixels, row-major |
| coef_mag | output | 512 | 64 coefficient magnitudes, 8 bits each, row-major by frequency |
| coef_neg | output | 64 | Per-coefficient negative flag |
| done | output | 1 | Result valid; held until the next accepted start |

## Verification
An all-zero tile checks that nothing appears from an empty input. A flat full-scale tile checks the exact DC value and that no AC leakage survives rounding. A checkerboard drives the highest frequency and many negative terms, so sign handling is exercised across all 64 positions against a real-valued cosine model. Horizontal and vertical ramps separate row from column orientation. A tile that changes and a start that is repeated mid-run show that the captured tile alone sets the result.

// File: rtl/dctq_pkg.sv
package dctq_pkg;

    localparam int PIX_W   = 8;               // input sample width
    localparam int BLK     = 8;               // transform length (lane is built for 8)
    localparam int NPIX    = BLK * BLK;       // samples per tile
    localparam int FRAC    = 12;              // fraction bits of the magnitude
    localparam int INTB    = 18;              // integer bits, room for column-pass growth
    localparam int MAG_W   = INTB + FRAC;     // magnitude width
    localparam int CONST_W = 16;              // reciprocal-cosine constant width
    localparam int OUT_W   = 8;               // output magnitude width
    localparam int QSHIFT  = 8;               // 1/4 output scale times 1/64 quantizer
    localparam int IDX_W   = $clog2(BLK);
    localparam int PASS_LAT = 2 * BLK + 1;    // accept edge to done edge

    // 1/(2cos(theta)) with FRAC fraction bits
    localparam logic [CONST_W-1:0] K_QTR = 16'd2896;   // theta = pi/4
    localparam logic [CONST_W-1:0] K_QRT [2] = '{16'd2217, 16'd5352};   // pi/8, 3pi/8
    localparam logic [CONST_W-1:0] K_OCT [4] =
        '{16'd2088, 16'd2463, 16'd3686, 16'd10498};  // pi/16, 3pi/16, 5pi/16, 7pi/16

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } sm_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_FIN
    } phase_e;

    // sign-magnitude addition; a zero result is always positive
    function automatic sm_t sm_add(input sm_t a, input sm_t b);
        sm_t r;
        if (a.neg == b.neg) begin
            r.mag = a.mag + b.mag;
            r.neg = a.neg;
        end else if (a.mag >= b.mag) begin
            r.mag = a.mag - b.mag;
            r.neg = a.neg;
        end else begin
            r.mag = b.mag - a.mag;
            r.neg = b.neg;
        end
        if (r.mag == '0) r.neg = 1'b0;
        return r;
    endfunction

    function automatic sm_t sm_sub(input sm_t a, input sm_t b);
        sm_t nb;
        nb.neg = ~b.neg;
        nb.mag = b.mag;
        return sm_add(a, nb);
    endfunction

    // multiply by a positive constant, truncate back to FRAC fraction bits
    function automatic sm_t sm_mul(input sm_t a, input logic [CONST_W-1:0] k);
        logic [MAG_W+CONST_W-1:0] p;
        sm_t r;
        p = {{CONST_W{1'b0}}, a.mag} * {{MAG_W{1'b0}}, k};
        r.mag = p[FRAC +: MAG_W];
        r.neg = a.neg & (r.mag != '0);
        return r;
    endfunction

    // 4-point recursive core: fold, scale, fold again, interleave
    function automatic sm_t [3:0] dct4_core(input sm_t [3:0] v);
        sm_t e0, e1, o0, o1, a0, a1, b0, b1;
        sm_t [3:0] r;
        e0 = sm_add(v[0], v[3]);
        e1 = sm_add(v[1], v[2]);
        o0 = sm_mul(sm_sub(v[0], v[3]), K_QRT[0]);
        o1 = sm_mul(sm_sub(v[1], v[2]), K_QRT[1]);
        a0 = sm_add(e0, e1);
        a1 = sm_mul(sm_sub(e0, e1), K_QTR);
        b0 = sm_add(o0, o1);
        b1 = sm_mul(sm_sub(o0, o1), K_QTR);
        r[0] = a0;
        r[2] = a1;
        r[1] = sm_add(b0, b1);
        r[3] = b1;
        return r;
    endfunction

endpackage

// File: rtl/dctq_lane8.sv
module dctq_lane8
    import dctq_pkg::*;
(
    input  sm_t [BLK-1:0] vec_i,
    output sm_t [BLK-1:0] vec_o
);

    localparam int HALF = BLK / 2;

    sm_t [HALF-1:0] fold_sum;
    sm_t [HALF-1:0] fold_dif;
    sm_t [HALF-1:0] even_q;
    sm_t [HALF-1:0] odd_q;

    // first fold: mirrored pairs, differences scaled by 1/(2cos)
    for (genvar n = 0; n < HALF; n++) begin : g_fold
        assign fold_sum[n] = sm_add(vec_i[n], vec_i[BLK-1-n]);
        assign fold_dif[n] = sm_mul(sm_sub(vec_i[n], vec_i[BLK-1-n]), K_OCT[n]);
    end

    assign even_q = dct4_core(fold_sum);
    assign odd_q  = dct4_core(fold_dif);

    // interleave: even outputs direct, odd outputs as neighbour sums
    for (genvar k = 0; k < HALF; k++) begin : g_gather
        assign vec_o[2*k] = even_q[k];
        if (k < HALF - 1) begin : g_pair
            assign vec_o[2*k+1] = sm_add(odd_q[k], odd_q[k+1]);
        end else begin : g_last
            assign vec_o[2*k+1] = odd_q[k];
        end
    end

endmodule

// File: rtl/dctq_ctl.sv
module dctq_ctl
    import dctq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [NPIX*PIX_W-1:0]   pix_i,
    output sm_t  [NPIX-1:0]         store_o,
    output logic                    take_o,
    output logic                    fin_o
);

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    sm_t [NPIX-1:0]   work;
    sm_t [BLK-1:0]    lane_in;
    sm_t [BLK-1:0]    lane_out;

    assign take_o  = start && (phase == ST_IDLE);
    assign fin_o   = (phase == ST_FIN);
    assign store_o = work;

    // pick a row or a column of the store for the shared lane
    always_comb begin
        for (int j = 0; j < BLK; j++) begin
            if (phase == ST_COL) lane_in[j] = work[j*BLK + int'(idx)];
            else                 lane_in[j] = work[int'(idx)*BLK + j];
        end
    end

    dctq_lane8 u_lane (
        .vec_i (lane_in),
        .vec_o (lane_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_IDLE;
            idx   <= '0;
            work  <= '0;
        end else begin
            case (phase)
                ST_IDLE: begin
                    if (start) begin
                        for (int i = 0; i < NPIX; i++) begin
                            work[i].neg <= 1'b0;
                            work[i].mag <= {{(MAG_W-PIX_W-FRAC){1'b0}},
                                            pix_i[i*PIX_W +: PIX_W], {FRAC{1'b0}}};
                        end
                        idx   <= '0;
                        phase <= ST_ROW;
                    end
                end
                ST_ROW: begin
                    for (int j = 0; j < BLK; j++)
                        work[int'(idx)*BLK + j] <= lane_out[j];
                    idx <= idx + 1'b1;
                    if (idx == IDX_W'(BLK-1)) phase <= ST_COL;
                end
                ST_COL: begin
                    for (int j = 0; j < BLK; j++)
                        work[j*BLK + int'(idx)] <= lane_out[j];
                    idx <= idx + 1'b1;
                    if (idx == IDX_W'(BLK-1)) phase <= ST_FIN;
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dctq_quant.sv
module dctq_quant
    import dctq_pkg::*;
(
    input  sm_t [NPIX-1:0]          val_i,
    output logic [NPIX*OUT_W-1:0]   mag_o,
    output logic [NPIX-1:0]         neg_o
);

    localparam int SH = FRAC + QSHIFT;
    localparam int RW = MAG_W + 1 - SH;
    localparam logic [MAG_W:0] HALF_LSB = {{(MAG_W-SH+1){1'b0}}, 1'b1, {(SH-1){1'b0}}};

    for (genvar i = 0; i < NPIX; i++) begin : g_q
        logic [MAG_W:0] biased;
        logic [RW-1:0]  whole;
        // rounding the magnitude gives round-half-away-from-zero on the value
        assign biased = {1'b0, val_i[i].mag} + HALF_LSB;
        assign whole  = biased[MAG_W:SH];
        assign mag_o[i*OUT_W +: OUT_W] = (|whole[RW-1:OUT_W]) ? {OUT_W{1'b1}}
                                                              : whole[OUT_W-1:0];
        assign neg_o[i] = val_i[i].neg & (whole != '0);
    end

endmodule

// File: rtl/dct8x8_q.sv
module dct8x8_q
    import dctq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [NPIX*PIX_W-1:0] pix_blk,
    output logic [NPIX*OUT_W-1:0] coef_mag,
    output logic [NPIX-1:0]       coef_neg,
    output logic                  done
);

    sm_t [NPIX-1:0]        store;
    logic                  take;
    logic                  fin;
    logic [NPIX*OUT_W-1:0] q_mag;
    logic [NPIX-1:0]       q_neg;

    dctq_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .pix_i   (pix_blk),
        .store_o (store),
        .take_o  (take),
        .fin_o   (fin)
    );

    dctq_quant u_quant (
        .val_i (store),
        .mag_o (q_mag),
        .neg_o (q_neg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            coef_mag <= '0;
            coef_neg <= '0;
            done     <= 1'b0;
        end else if (fin) begin
            coef_mag <= q_mag;
            coef_neg <= q_neg;
            done     <= 1'b1;
        end else if (take) begin
            done     <= 1'b0;
        end
    end

endmodule

// File: rtl/dctq_chk.sv
module dctq_chk
    import dctq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic [NPIX*OUT_W-1:0] coef_mag,
    input logic [NPIX-1:0]       coef_neg,
    input logic                  done
);

    localparam int CW = $clog2(PASS_LAT + 1);

    // independent run tracker: starts on an accepted start, ignores further starts
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (run_cnt == '0) begin
            if (start) run_cnt <= CW'(1);
        end else if (run_cnt == CW'(PASS_LAT)) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R1: state just after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && coef_mag == '0 && coef_neg == '0));

    // R2: done rises exactly PASS_LAT edges after acceptance
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(run_cnt) == CW'(PASS_LAT)));

    // R3: no done while a run is in flight, repeated starts notwithstanding
    a_r3_quiet_run: assert property (@(posedge clk) disable iff (rst)
        (run_cnt != '0) |-> !done);

    // R9: result and flag hold until the next start
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(coef_mag) && $stable(coef_neg)));

    // R8: a zero magnitude never carries a negative flag
    for (genvar i = 0; i < NPIX; i++) begin : g_sign
        a_r8_zero_pos: assert property (@(posedge clk) disable iff (rst)
            coef_neg[i] |-> (coef_mag[i*OUT_W +: OUT_W] != '0));
    end

endmodule

bind dct8x8_q dctq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .coef_mag (coef_mag),
    .coef_neg (coef_neg),
    .done     (done)
);

// File: tb/test_dct8x8_q.sv
module test_dct8x8_q;

    localparam real PI = 3.14159265358979;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [511:0] pix_blk = '0;
    logic [511:0] coef_mag;
    logic [63:0]  coef_neg;
    logic         done;

    int n_chk = 0;
    int n_err = 0;
    byte unsigned px [64];

    dct8x8_q i_dct8x8_q (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .pix_blk  (pix_blk),
        .coef_mag (coef_mag),
        .coef_neg (coef_neg),
        .done     (done)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int coef_val(input int i);
        int m;
        m = int'(coef_mag[i*8 +: 8]);
        return coef_neg[i] ? -m : m;
    endfunction

    function automatic int model_q(input int u, input int v);
        real acc;
        real q;
        acc = 0.0;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                acc += real'(px[r*8+c]) * $cos(real'((2*c+1)*v) * PI / 16.0)
                                        * $cos(real'((2*r+1)*u) * PI / 16.0);
        q = acc / 256.0;
        if (q >= 0.0) return int'($floor(q + 0.5));
        return -int'($floor(-q + 0.5));
    endfunction

    task automatic drive_px();
        for (int i = 0; i < 64; i++) pix_blk[i*8 +: 8] = px[i];
    endtask

    // pulse start, return done just after acceptance and edges until done
    task automatic run_block(output int lat, output bit done_after_take);
        @(negedge clk);
        drive_px();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        done_after_take = done;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic cmp_model(input string req);
        int bad = 0;
        int fa = 0;
        int fe = 0;
        for (int i = 0; i < 64; i++) begin
            int e;
            int a;
            e = model_q(i / 8, i % 8);
            a = coef_val(i);
            if (a - e > 1 || e - a > 1) begin
                if (bad == 0) begin fa = a; fe = e; end
                bad++;
            end
        end
        chk(bad == 0, req, "coefficients vs cosine model", fa, fe);
    endtask

    task automatic zero_sign(input string req);
        int bad = 0;
        for (int i = 0; i < 64; i++)
            if (coef_neg[i] && coef_mag[i*8 +: 8] == 8'd0) bad++;
        chk(bad == 0, req, "zero magnitudes flagged negative", bad, 0);
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(coef_mag == '0, "R1", "magnitudes after reset", int'(coef_mag[7:0]), 0);
        chk(coef_neg == '0, "R1", "negative flags after reset", int'(coef_neg[31:0]), 0);
    endtask

    task automatic t_zero();
        int lat;
        bit d0;
        foreach (px[i]) px[i] = 8'd0;
        run_block(lat, d0);
        chk(lat == 17, "R2", "latency zero tile", lat, 17);
        chk(coef_mag == '0, "R6", "zero tile magnitudes", int'(coef_mag[7:0]), 0);
        chk(coef_neg == '0, "R6", "zero tile flags", int'(coef_neg[31:0]), 0);
    endtask

    task automatic t_flat();
        int lat;
        bit d0;
        foreach (px[i]) px[i] = 8'd255;
        run_block(lat, d0);
        chk(d0 == 1'b0, "R2", "done cleared on accept", int'(d0), 0);
        chk(lat == 17, "R2", "latency flat tile", lat, 17);
        chk(coef_val(0) == 64, "R7", "flat tile DC", coef_val(0), 64);
        chk(coef_mag[511:8] == '0, "R7", "flat tile AC", int'(coef_mag[15:8]), 0);
    endtask

    task automatic t_checker();
        int lat;
        bit d0;
        foreach (px[i]) px[i] = (((i / 8) + (i % 8)) % 2 == 1) ? 8'd255 : 8'd0;
        run_block(lat, d0);
        chk(lat == 17, "R2", "latency checkerboard", lat, 17);
        cmp_model("R5");
        zero_sign("R8");
        chk(coef_val(0) == 32, "R5", "checkerboard DC", coef_val(0), 32);
    endtask

    task automatic t_hramp();
        int lat;
        bit d0;
        foreach (px[i]) px[i] = 8'((i % 8) * 32);
        run_block(lat, d0);
        cmp_model("R5");
        chk(coef_neg[1] == 1'b1 && coef_mag[15:8] != 0, "R8", "column ramp (0,1) negative",
            coef_val(1), model_q(0, 1));
        chk(coef_mag[71:64] == 8'd0, "R4", "column ramp (1,0) empty", coef_val(8), 0);
        zero_sign("R8");
    endtask

    task automatic t_vramp();
        int lat;
        bit d0;
        foreach (px[i]) px[i] = 8'((i / 8) * 32);
        run_block(lat, d0);
        cmp_model("R5");
        chk(coef_mag[71:64] != 8'd0 && coef_neg[8], "R4", "row ramp (1,0) present",
            coef_val(8), model_q(1, 0));
        chk(coef_mag[15:8] == 8'd0, "R4", "row ramp (0,1) empty", coef_val(1), 0);
    endtask

    task automatic t_busy();
        int lat;
        foreach (px[i]) px[i] = (((i / 8) + (i % 8)) % 2 == 1) ? 8'd255 : 8'd0;
        @(negedge clk);
        drive_px();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (lat == 5) begin
                pix_blk = '0;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        chk(lat == 17, "R3", "latency with mid-run start", lat, 17);
        cmp_model("R3");
    endtask

    task automatic t_hold();
        logic [511:0] m0;
        logic [63:0]  n0;
        m0 = coef_mag;
        n0 = coef_neg;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            pix_blk = {16{32'hA5C3_1E77}} ^ {16{32'(k)}};
        end
        chk(done == 1'b1, "R9", "done held", int'(done), 1);
        chk(coef_mag == m0 && coef_neg == n0, "R9", "result held",
            int'(coef_mag[7:0]), int'(m0[7:0]));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R2", "done drops after new start", int'(done), 0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero();
        t_flat();
        t_checker();
        t_hramp();
        t_vramp();
        t_busy();
        t_hold();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule